// File: doc/BRIEF.md
# Standby wake-up clock sequencer

This block drives three enables around a low-power stop state: the oscillator enable, the PLL enable and the gate that releases the clock to internal logic. In the run state all three are high. A stop request from software drops all three and parks a stabilization counter at zero. A wake-up interrupt restarts the oscillator and the counter with the PLL still off.

One programmed stabilization count is split into two halves. The PLL is enabled when the counter reaches the midpoint. The second half is the PLL lock wait, and the internal clock stays gated during it. At the full count the gate opens and the block returns to the run state it held before the stop.

A 3-bit select picks the length of the count. Software may write it only in the run state. A reset-type event of any kind (external, low-voltage or power-on) arrives on the reset input. It overrides the interrupt wake path and puts the block back in its power-on run state.

Top module: `wake_clk_seq`

## Requirements
- R1: A stop request in the run state with no wake interrupt pending moves the block to the stop state one clock later. In the stop state osc_en_o, pll_en_o and clk_gate_en_o are all low.
- R2: The stabilization counter is held at zero while stopped, so every wake counts from zero. The oscillator-wait phase of each wake lasts the same number of cycles, whatever came before.
- R3: A wake interrupt seen in the stop state moves the block to the oscillator-wait state one clock later. In that state osc_en_o is high and pll_en_o and clk_gate_en_o are low.
- R4: The oscillator-wait state lasts exactly half the programmed count, in cycles. pll_en_o rises on the first cycle after it.
- R5: The PLL lock-wait state lasts the other half of the count. In it pll_en_o and osc_en_o are high and clk_gate_en_o stays low.
- R6: When the full count is reached the block returns to the run state, with osc_en_o, pll_en_o and clk_gate_en_o all high.
- R7: Asserting rst_ni low, from any state and at any point in a wake, returns the block to the run state with all enables high and the select reset to 0.
- R8: The programmed count is 2^(BASE_LOG2+2*sel) cycles, where sel is the stored select (default BASE_LOG2 = 10). A write with sel_wr_i takes effect only in the run state and is ignored in every other state.
- R9: A stop request while wake_irq_i is high is ignored, and the block stays in the run state.
- R10: state_o encodes the state as run = 0, stop = 1, oscillator wait = 2 and PLL lock wait = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Model oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset; any reset-type event |
| stop_req_i | input | 1 | Software stop request |
| wake_irq_i | input | 1 | Pending wake-up interrupt |
| sel_wr_i | input | 1 | Write strobe for the stabilization select |
| sel_i | input | SEL_W | Stabilization-time select value |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| clk_gate_en_o | output | 1 | Internal clock gate enable |
| state_o | output | 2 | Current sequencer state |

## Verification
The hardest case to reach is a select write or a reset that lands in the middle of a wake. The stored select cannot be read back, and the counter runs only between a wake and the return to run. The bench therefore writes a new select while the block is stopped and checks that the next wake times both halves with the old count. It also pulls reset partway through the lock wait and checks that the following wake uses the reset select value. With a small BASE_LOG2, the bench counts every oscillator-wait and lock-wait cycle exactly, for several select values.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_OSC  = 2'd2,
    ST_LOCK = 2'd3
  } wcs_state_e;
endpackage

// File: rtl/wcs_sel_reg.sv
module wcs_sel_reg #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_o
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            sel_q <= '0;
    else if (wr_i && run_i) sel_q <= sel_i;
  end

  assign sel_o = sel_q;

  // R8: outside run, writes leave the select untouched
  p_sel_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && wr_i) |=> $stable(sel_q));
endmodule

// File: rtl/wcs_stab_cnt.sv
module wcs_stab_cnt #(
  parameter int unsigned BASE_LOG2 = 10,
  parameter int unsigned SEL_W     = 3,
  localparam int unsigned CW       = BASE_LOG2 + 2 * ((1 << SEL_W) - 1) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CW-1:0]    cnt_o,
  output logic [CW-1:0]    half_o,
  output logic             half_hit_o,
  output logic             full_hit_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] full_c;
  logic [CW-1:0] half_c;

  assign full_c = CW'(1) << (BASE_LOG2 + 2 * int'(sel_i));
  assign half_c = full_c >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o      = cnt_q;
  assign half_o     = half_c;
  assign half_hit_o = (cnt_q == half_c - CW'(1));
  assign full_hit_o = (cnt_q == full_c - CW'(1));

  // R2: counting never goes past the full value
  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |-> (cnt_q < full_c));
endmodule

// File: rtl/wcs_fsm.sv
module wcs_fsm
  import wcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_req_i,
  input  logic       wake_irq_i,
  input  logic       half_hit_i,
  input  logic       full_hit_i,
  output wcs_state_e state_o,
  output logic       cnt_clr_o,
  output logic       cnt_en_o,
  output logic       osc_en_o,
  output logic       pll_en_o,
  output logic       gate_en_o
);
  wcs_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (stop_req_i && !wake_irq_i) st_d = ST_STOP;
      ST_STOP: if (wake_irq_i)                st_d = ST_OSC;
      ST_OSC:  if (half_hit_i)                st_d = ST_LOCK;
      ST_LOCK: if (full_hit_i)                st_d = ST_RUN;
      default:                                st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign state_o   = st_q;
  assign cnt_clr_o = (st_q == ST_RUN) || (st_q == ST_STOP);
  assign cnt_en_o  = (st_q == ST_OSC) || (st_q == ST_LOCK);
  assign osc_en_o  = (st_q != ST_STOP);
  assign pll_en_o  = (st_q == ST_RUN) || (st_q == ST_LOCK);
  assign gate_en_o = (st_q == ST_RUN);

  // R3: interrupt in stop starts the oscillator wait
  p_wake_path_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STOP && wake_irq_i) |=> (st_q == ST_OSC && osc_en_o && !pll_en_o));
  // R9: a pending wake blocks the stop request
  p_stop_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && wake_irq_i) |=> (st_q == ST_RUN));
  // R1: stop entry drops both enables
  p_stop_entry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && stop_req_i && !wake_irq_i) |=> (!osc_en_o && !pll_en_o));
endmodule

// File: rtl/wake_clk_seq.sv
module wake_clk_seq
  import wcs_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 10,
  parameter int unsigned SEL_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_req_i,
  input  logic             wake_irq_i,
  input  logic             sel_wr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             osc_en_o,
  output logic             pll_en_o,
  output logic             clk_gate_en_o,
  output logic [1:0]       state_o
);
  localparam int unsigned CW = BASE_LOG2 + 2 * ((1 << SEL_W) - 1) + 1;

  wcs_state_e       st;
  logic             cnt_clr, cnt_en, half_hit, full_hit;
  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]    cnt, half_v;

  wcs_sel_reg #(.SEL_W(SEL_W)) u_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (sel_wr_i),
    .run_i (st == ST_RUN),
    .sel_i (sel_i),
    .sel_o (sel_q)
  );

  wcs_stab_cnt #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cnt_clr),
    .en_i      (cnt_en),
    .sel_i     (sel_q),
    .cnt_o     (cnt),
    .half_o    (half_v),
    .half_hit_o(half_hit),
    .full_hit_o(full_hit)
  );

  wcs_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stop_req_i(stop_req_i),
    .wake_irq_i(wake_irq_i),
    .half_hit_i(half_hit),
    .full_hit_i(full_hit),
    .state_o   (st),
    .cnt_clr_o (cnt_clr),
    .cnt_en_o  (cnt_en),
    .osc_en_o  (osc_en_o),
    .pll_en_o  (pll_en_o),
    .gate_en_o (clk_gate_en_o)
  );

  assign state_o = st;

  // R2: counter parked at zero while stopped
  p_cnt_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_STOP) |-> (cnt == '0));
  // R4: PLL starts exactly at the midpoint
  p_pll_mid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_LOCK && $rose(pll_en_o)) |-> (cnt == half_v));
  // R5: gate closed for the whole lock wait
  p_gate_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_LOCK) |-> (!clk_gate_en_o && pll_en_o && osc_en_o));
  // R6: return to run opens the gate
  p_run_resume_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_LOCK && full_hit) |=> (st == ST_RUN && clk_gate_en_o));
endmodule

// File: tb/wake_clk_seq_bench.sv
`timescale 1ns/1ps
module wake_clk_seq_bench;
  localparam int unsigned BASE = 2;
  localparam int unsigned SW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, wake = 1'b0, sel_wr = 1'b0;
  logic [SW-1:0] sel = '0;
  logic osc_en, pll_en, gate_en;
  logic [1:0] st;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  wake_clk_seq #(.BASE_LOG2(BASE), .SEL_W(SW)) u_wake_clk_seq (
    .clk_i(clk), .rst_ni(rst_n), .stop_req_i(stop_req), .wake_irq_i(wake),
    .sel_wr_i(sel_wr), .sel_i(sel), .osc_en_o(osc_en), .pll_en_o(pll_en),
    .clk_gate_en_o(gate_en), .state_o(st)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {29'd0, osc_en, pll_en, gate_en};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic enter_stop();
    stop_req = 1'b1; tick(); stop_req = 1'b0;
    chk("R1 state stop", st, 1);
    chk("R1 enables off", outs(), 0);
  endtask

  // full wake with cycle counts for select s
  task automatic wake_and_time(input int s, input string tag);
    int half = 1 << (BASE + 2 * s - 1);
    int n_osc = 0, n_lock = 0;
    wake = 1'b1; tick(); wake = 1'b0;
    chk({"R3 state osc ", tag}, st, 2);
    chk({"R3 osc on pll off ", tag}, outs(), 3'b100);
    for (int i = 0; i < 70000 && st == 2; i++) begin n_osc++; tick(); end
    chk({"R4 osc wait len ", tag}, n_osc, half);
    chk({"R5 state lock ", tag}, st, 3);
    chk({"R5 pll on gate off ", tag}, outs(), 3'b110);
    for (int i = 0; i < 70000 && st == 3; i++) begin n_lock++; tick(); end
    chk({"R5 lock wait len ", tag}, n_lock, half);
    chk({"R6 back to run ", tag}, st, 0);
    chk({"R6 all enables ", tag}, outs(), 3'b111);
  endtask

  task automatic write_sel(input int s);
    sel = SW'(s); sel_wr = 1'b1; tick(); sel_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R7 reset run", st, 0);
    chk("R10 run code", st, 0);
    chk("R7 reset enables", outs(), 3'b111);
  endtask

  task automatic t_basic(input int s);
    write_sel(s);
    enter_stop();
    for (int i = 0; i < 4; i++) tick();
    chk("R2 stays stopped", st, 1);
    wake_and_time(s, $sformatf("R8 sel%0d", s));
  endtask

  task automatic t_blocked_stop();
    wake = 1'b1; stop_req = 1'b1; tick(); tick();
    stop_req = 1'b0; wake = 1'b0;
    chk("R9 stop ignored", st, 0);
    chk("R9 enables kept", outs(), 3'b111);
  endtask

  task automatic t_sel_ignored();
    write_sel(1);
    enter_stop();
    write_sel(3);
    wake_and_time(1, "R8 write in stop ignored");
  endtask

  task automatic t_stop_in_wake_ignored();
    write_sel(1);
    enter_stop();
    wake = 1'b1; tick(); wake = 1'b0;
    stop_req = 1'b1; tick(); stop_req = 1'b0;
    chk("R3 stop ignored in osc wait", st, 2);
    for (int i = 0; i < 70000 && st != 0; i++) tick();
    chk("R6 completes after stray stop", st, 0);
  endtask

  task automatic t_reset_mid_wake();
    write_sel(2);
    enter_stop();
    wake = 1'b1; tick(); wake = 1'b0;
    for (int i = 0; i < 70000 && st != 3; i++) tick();
    tick();
    chk("R10 lock code", st, 3);
    rst_n = 1'b0; #1;
    chk("R7 reset mid wake run", st, 0);
    chk("R7 reset mid wake enables", outs(), 3'b111);
    tick(); rst_n = 1'b1; tick();
    enter_stop();
    wake_and_time(0, "R7 sel back to 0");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1'b1; tick();
    t_reset();
    t_basic(0);
    t_basic(1);
    t_basic(3);
    t_blocked_stop();
    t_sel_ignored();
    t_stop_in_wake_ignored();
    t_reset_mid_wake();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule